// File: doc/BRIEF.md
# A/D Conversion Sequencer with External Trigger

This block is the digital controller for an on-chip successive-approximation analog-to-digital converter working in single-channel mode. A conversion is launched either by software setting the start bit in a five-bit control/status register, or by a falling edge on an active-low external trigger pin while trigger mode is enabled. Both launch paths lead to the same conversion sequence.

The sequence first aligns to the phase of a free-running prescaler. It then times a fixed start delay, a sampling window and a conversion period. All lengths are counted in clock cycles and are picked by a clock-select bit, which is latched when the conversion starts. The analog comparator and DAC are stood in for by a behavioural input, `ana_value`. Its value is held at the close of the sampling window. The held value is copied into the result register one cycle before the end flag rises.

When a conversion completes, the start bit clears itself and the end flag is set. The interrupt line follows the end flag when interrupts are enabled, and the same line serves as a DMA request. A DMA read strobe clears the flag. Software can also clear it by reading the register while the flag is 1 and then writing the flag bit as 0. Writing the start bit as 0 during a conversion aborts it without setting the flag.

The state machine has five states:
- IDLE: no conversion. A start request (go) moves it to ALIGN.
- ALIGN: waits for the last prescaler phase, then moves to DELAY.
- DELAY: fixed count, then moves to SAMPLE.
- SAMPLE: the sampling window. On its last count the input is held and the machine moves to CONVERT.
- CONVERT: on its last count (done) it returns to IDLE.

An abort returns the machine to IDLE from any busy state.

Top module: `adc_seq`

## Requirements
- R1: After reset the control/status register reads 0, `irq` and `smp_active` are 0, and `result` is 0.
- R2: A write with bit 0 (start) at 1 while idle makes bit 0 read 1 from the next cycle on.
- R3: With clock select (bit 2) at 0, `smp_active` rises 10 to 17 cycles after the start edge and stays high for exactly 64 cycles. The end flag rises 259 to 266 cycles after the start edge.
- R4: With clock select at 1, `smp_active` rises 6 to 9 cycles after the start edge and stays high for exactly 32 cycles. The end flag rises 131 to 134 cycles after the start edge.
- R5: At completion the end flag (bit 4) is set and bit 0 clears in the same cycle. `result` equals `ana_value` as sampled at the last clock edge of the sampling window, and `result` already holds that value one cycle before the flag rises.
- R6: `irq` is 1 exactly when the end flag is 1 and interrupt enable (bit 1) is 1.
- R7: With trigger enable (bit 3) at 1, a falling edge on `trig_n` sets bit 0 on the third clock edge after the pin is first sampled low. A pin held low does not start another conversion. With trigger enable at 0 the pin is ignored.
- R8: Writing bit 0 as 0 during a conversion returns the sequencer to idle. The end flag is not set and `result` is unchanged.
- R9: A write with bit 4 at 0 clears the end flag only if a read (`csr_rd`) has returned the flag as 1 since the flag was last cleared. A write with bit 4 at 1 leaves the flag unchanged.
- R10: A `dma_rd` strobe clears the end flag.
- R11: Writes made during a conversion, including a change of clock select or a repeated start, do not alter that conversion's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Control/status register write strobe |
| csr_rd | input | 1 | Control/status register read strobe (arms the flag clear) |
| csr_wdata | input | 5 | Write data: bit 0 start, 1 irq enable, 2 clock select, 3 trigger enable, 4 end flag |
| csr_rdata | output | 5 | Register read data, same bit layout |
| dma_rd | input | 1 | DMA read of a converter register; clears the end flag |
| trig_n | input | 1 | Asynchronous active-low external trigger |
| ana_value | input | 10 | Behavioural comparator/DAC result |
| result | output | 10 | Conversion result register |
| smp_active | output | 1 | High during the sampling window |
| irq | output | 1 | End-of-conversion interrupt / DMA request |

## Verification
A software start is visible on bit 0 one cycle after the write. A trigger start appears three edges after the pin first samples low. The bench therefore checks bit 0 at the exact negative edge where it is due, and one edge earlier for the trigger path. The sampling delay, sampling width and total conversion time depend on the prescaler phase, so the bench counts negative edges from the start edge and checks each against the range or exact width set for the chosen clock select. The result is compared at the first negative edge where the flag is 1 and again at the edge before it. Flag clears and aborts are checked at the negative edge after the strobe.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ALIGN,
        S_DELAY,
        S_SAMPLE,
        S_CONVERT
    } seq_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // control/status bit positions
    localparam int B_START = 0;
    localparam int B_IEN   = 1;
    localparam int B_CKS   = 2;
    localparam int B_TRGEN = 3;
    localparam int B_FLAG  = 4;
    localparam int CSR_W   = 5;

endpackage

// File: rtl/adc_seq_presc.sv
module adc_seq_presc #(
    parameter int PHASE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PHASE_W-1:0] phase
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 1'b1;
    end

endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);

    logic [SYNC:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[SYNC-1:0], pin_n};
    end

    assign fall = sh[SYNC] & ~sh[SYNC-1];

    // one falling edge gives a single-cycle pulse
    assert_fall_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int PRE_SLOW_LG = 3,
    parameter int PRE_FAST_LG = 2,
    parameter int DLY_SLOW    = 9,
    parameter int DLY_FAST    = 5,
    parameter int SMP_SLOW    = 64,
    parameter int SMP_FAST    = 32,
    parameter int CNV_SLOW    = 185,
    parameter int CNV_FAST    = 93
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go,
    input  logic                   abort,
    input  logic                   cks,
    input  logic [PRE_SLOW_LG-1:0] phase,
    input  logic [RES_W-1:0]       ana_value,
    output logic                   busy,
    output logic                   smp_active,
    output logic                   in_convert,
    output logic                   done,
    output logic [RES_W-1:0]       result
);

    localparam int MAXLEN = max2(max2(max2(DLY_SLOW, DLY_FAST), max2(SMP_SLOW, SMP_FAST)),
                                 max2(CNV_SLOW, CNV_FAST));
    localparam int CNT_W  = $clog2(MAXLEN + 1);

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             cks_act;
    logic [RES_W-1:0] held;
    logic [CNT_W-1:0] dly_end, smp_end, cnv_end, load_pt;
    logic             phase_last;

    always_comb begin
        dly_end    = cks_act ? CNT_W'(DLY_FAST - 1) : CNT_W'(DLY_SLOW - 1);
        smp_end    = cks_act ? CNT_W'(SMP_FAST - 1) : CNT_W'(SMP_SLOW - 1);
        cnv_end    = cks_act ? CNT_W'(CNV_FAST - 1) : CNT_W'(CNV_SLOW - 1);
        load_pt    = cks_act ? CNT_W'(CNV_FAST - 2) : CNT_W'(CNV_SLOW - 2);
        phase_last = cks_act ? (&phase[PRE_FAST_LG-1:0]) : (&phase);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (abort) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:    if (go)             nxt = S_ALIGN;
                S_ALIGN:   if (phase_last)     nxt = S_DELAY;
                S_DELAY:   if (cnt == dly_end) nxt = S_SAMPLE;
                S_SAMPLE:  if (cnt == smp_end) nxt = S_CONVERT;
                S_CONVERT: if (cnt == cnv_end) nxt = S_IDLE;
                default:                       nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // phase counter, restarted on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (nxt != state) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // clock select latched at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cks_act <= 1'b0;
        else if (state == S_IDLE && go)  cks_act <= cks;
    end

    // sample-and-hold at close of the sampling window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   held <= '0;
        else if (state == S_SAMPLE && nxt == S_CONVERT) held <= ana_value;
    end

    // result loaded one cycle ahead of completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                               result <= '0;
        else if (state == S_CONVERT && cnt == load_pt && !abort)  result <= held;
    end

    // outputs
    always_comb begin
        busy       = (state != S_IDLE);
        smp_active = (state == S_SAMPLE);
        in_convert = (state == S_CONVERT);
        done       = (state == S_CONVERT) && (cnt == cnv_end) && !abort;
    end

    // sampling counter never passes the window length
    assert_smp_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SAMPLE) |-> (cnt <= smp_end));

    // clock select is frozen for the whole conversion
    assert_cks_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cks_act));

endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int PRE_SLOW_LG = 3,
    parameter int PRE_FAST_LG = 2,
    parameter int DLY_SLOW    = 9,
    parameter int DLY_FAST    = 5,
    parameter int SMP_SLOW    = 64,
    parameter int SMP_FAST    = 32,
    parameter int CNV_SLOW    = 185,
    parameter int CNV_FAST    = 93,
    parameter int SYNC        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic             csr_rd,
    input  logic [4:0]       csr_wdata,
    output logic [4:0]       csr_rdata,
    input  logic             dma_rd,
    input  logic             trig_n,
    input  logic [RES_W-1:0] ana_value,
    output logic [RES_W-1:0] result,
    output logic             smp_active,
    output logic             irq
);

    logic [PRE_SLOW_LG-1:0] phase;
    logic trig_fall, go, abort, busy, in_convert, done;
    logic irq_en, cks, trig_en, flag_q, armed;

    adc_seq_presc #(.PHASE_W(PRE_SLOW_LG)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    adc_seq_trig #(.SYNC(SYNC)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (trig_n),
        .fall  (trig_fall)
    );

    assign go    = !busy && ((csr_wr && csr_wdata[B_START]) || (trig_en && trig_fall));
    assign abort =  busy &&   csr_wr && !csr_wdata[B_START];

    adc_seq_fsm #(
        .RES_W(RES_W), .PRE_SLOW_LG(PRE_SLOW_LG), .PRE_FAST_LG(PRE_FAST_LG),
        .DLY_SLOW(DLY_SLOW), .DLY_FAST(DLY_FAST),
        .SMP_SLOW(SMP_SLOW), .SMP_FAST(SMP_FAST),
        .CNV_SLOW(CNV_SLOW), .CNV_FAST(CNV_FAST)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .abort      (abort),
        .cks        (cks),
        .phase      (phase),
        .ana_value  (ana_value),
        .busy       (busy),
        .smp_active (smp_active),
        .in_convert (in_convert),
        .done       (done),
        .result     (result)
    );

    // configuration bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en  <= 1'b0;
            cks     <= 1'b0;
            trig_en <= 1'b0;
        end else if (csr_wr) begin
            irq_en  <= csr_wdata[B_IEN];
            cks     <= csr_wdata[B_CKS];
            trig_en <= csr_wdata[B_TRGEN];
        end
    end

    // end flag with read-then-write-0 and DMA clearing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            armed  <= 1'b0;
        end else if (done) begin
            flag_q <= 1'b1;
        end else if (dma_rd || (csr_wr && !csr_wdata[B_FLAG] && armed)) begin
            flag_q <= 1'b0;
            armed  <= 1'b0;
        end else if (csr_rd && flag_q) begin
            armed  <= 1'b1;
        end
    end

    assign csr_rdata = {flag_q, trig_en, cks, irq_en, busy};
    assign irq       = flag_q && irq_en;

    // the flag only rises as a conversion ends
    assert_flag_from_convert_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(in_convert));

    // the result settles before the flag is seen
    assert_result_before_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $stable(result));

    // an aborted conversion never sets the flag
    assert_abort_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !flag_q) |=> !flag_q);

endmodule

// File: tb/adc_seq_test.sv
`timescale 1ns/1ps
module adc_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csr_wr = 1'b0, csr_rd = 1'b0, dma_rd = 1'b0, trig_n = 1'b1;
    logic [4:0] csr_wdata = '0;
    logic [4:0] csr_rdata;
    logic [9:0] ana_value = '0;
    logic [9:0] result;
    logic       smp_active, irq;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    always #10 clk = ~clk;

    adc_seq uut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rd(csr_rd),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .dma_rd(dma_rd),
        .trig_n(trig_n), .ana_value(ana_value), .result(result),
        .smp_active(smp_active), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected timing windows from the requirements
    function automatic int lo_dly(input bit ck); return ck ? 6 : 10;    endfunction
    function automatic int hi_dly(input bit ck); return ck ? 9 : 17;    endfunction
    function automatic int smp_len(input bit ck); return ck ? 32 : 64;  endfunction
    function automatic int lo_tot(input bit ck); return ck ? 131 : 259; endfunction
    function automatic int hi_tot(input bit ck); return ck ? 134 : 266; endfunction

    task automatic csr_write(input logic [4:0] d);
        csr_wdata = d; csr_wr = 1'b1;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read();
        csr_rd = 1'b1;
        @(negedge clk);
        csr_rd = 1'b0;
    endtask

    task automatic run_conv(input bit ck, input bit ien, input bit trig,
                            input bit hold, input bit midwr, input int clr);
        logic [4:0] ctrl;
        logic [9:0] expv, prevr;
        int n, n_smp, n_flag, scnt, off, d, t;
        string rq;
        ctrl = {1'b0, trig, ck, ien, 1'b0};
        rq = midwr ? "R11" : (ck ? "R4" : "R3");
        csr_write(ctrl);
        repeat ($urandom % 9) @(negedge clk);
        if (trig) trig_n = 1'b0;
        else begin csr_wdata = ctrl | 5'd1; csr_wr = 1'b1; end
        off = trig ? 2 : 0;
        n = 0; n_smp = 0; n_flag = 0; scnt = 0; expv = '0; prevr = result;
        while (n_flag == 0 && n < 400) begin
            @(negedge clk);
            n++;
            csr_wr = 1'b0;
            if (trig && !hold && n == 5) trig_n = 1'b1;
            if (trig && n == 2) chk(csr_rdata[0] == 1'b0, "R7 start early", csr_rdata[0], 0);
            if (trig && n == 3) chk(csr_rdata[0] == 1'b1, "R7 trigger start", csr_rdata[0], 1);
            if (!trig && n == 1) chk(csr_rdata[0] == 1'b1, "R2 start bit", csr_rdata[0], 1);
            if (smp_active) begin
                scnt++;
                if (n_smp == 0) n_smp = n;
            end
            if (csr_rdata[4]) begin
                n_flag = n;
                chk(result == expv, "R5 result", result, expv);
                chk(prevr == expv, "R5 result before flag", prevr, expv);
            end
            if (midwr && n == 60) begin
                csr_wdata = (ctrl ^ 5'b00100) | 5'd1; csr_wr = 1'b1;
            end
            prevr = result;
            ana_value = 10'($urandom);
            if (smp_active) expv = ana_value;
        end
        d = n_smp - 1 - off;
        t = n_flag - 1 - off;
        chk(d >= lo_dly(ck) && d <= hi_dly(ck), {rq, " start delay"}, d, lo_dly(ck));
        chk(scnt == smp_len(ck), {rq, " sampling width"}, scnt, smp_len(ck));
        chk(t >= lo_tot(ck) && t <= hi_tot(ck), {rq, " total time"}, t, lo_tot(ck));
        chk(csr_rdata[0] == 1'b0, "R5 start cleared", csr_rdata[0], 0);
        chk(irq == ien, "R6 irq", irq, ien);
        if (hold) begin
            repeat (20) @(negedge clk);
            chk(csr_rdata[0] == 1'b0, "R7 held low no restart", csr_rdata[0], 0);
        end
        trig_n = 1'b1;
        if (clr == 0) begin
            dma_rd = 1'b1;
            @(negedge clk);
            dma_rd = 1'b0;
            chk(csr_rdata[4] == 1'b0, "R10 dma clear", csr_rdata[4], 0);
        end else if (clr == 1) begin
            csr_read();
            csr_write(ctrl);
            chk(csr_rdata[4] == 1'b0, "R9 read then write clear", csr_rdata[4], 0);
        end
        if (clr != 2) chk(irq == 1'b0, "R6 irq after clear", irq, 0);
    endtask

    initial begin
        logic [9:0] r0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(csr_rdata == 5'd0, "R1 reset csr", csr_rdata, 0);
        chk(irq == 1'b0, "R1 reset irq", irq, 0);
        chk(smp_active == 1'b0, "R1 reset smp", smp_active, 0);
        chk(result == 10'd0, "R1 reset result", result, 0);

        // directed: both clock selects, both start paths
        run_conv(0, 1, 0, 0, 0, 0);
        run_conv(1, 1, 0, 0, 0, 1);
        run_conv(0, 0, 1, 0, 0, 0);
        run_conv(1, 1, 1, 1, 0, 1);
        run_conv(0, 1, 0, 0, 1, 0);

        // R9: write-0 only clears after a read, write-1 never clears
        run_conv(1, 1, 0, 0, 0, 2);
        csr_write(5'b00010);
        chk(csr_rdata[4] == 1'b1, "R9 no clear without read", csr_rdata[4], 1);
        csr_read();
        csr_write(5'b10010);
        chk(csr_rdata[4] == 1'b1, "R9 write one keeps flag", csr_rdata[4], 1);
        csr_write(5'b00010);
        chk(csr_rdata[4] == 1'b0, "R9 armed clear", csr_rdata[4], 0);

        // R8: abort mid conversion
        csr_write(5'b00011);
        repeat (100) @(negedge clk);
        r0 = result;
        csr_write(5'b00010);
        chk(csr_rdata[0] == 1'b0, "R8 abort to idle", csr_rdata[0], 0);
        repeat (300) @(negedge clk);
        chk(csr_rdata[4] == 1'b0, "R8 no flag", csr_rdata[4], 0);
        chk(irq == 1'b0, "R8 no irq", irq, 0);
        chk(result == r0, "R8 result kept", result, r0);

        // R7: trigger ignored when disabled
        csr_write(5'b00000);
        trig_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(csr_rdata[0] == 1'b0, "R7 trigger disabled", csr_rdata[0], 0);
        trig_n = 1'b1;
        repeat (3) @(negedge clk);

        // random mix
        for (int i = 0; i < 16; i++) begin
            run_conv(1'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'b0, int'($urandom % 2));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule